// File: doc/BRIEF.md
# Address-Pattern Bank Switch Recognizer

This block is the bank selector of a banked bytewide memory unit. The unit's address window holds only one 32-kbyte bank, so a host picks among up to sixteen banks without any writable register. Instead it issues a fixed series of read cycles whose upper address bits spell out a 64-bit key. The block samples four address lines on each completed read cycle. When all sixteen key steps have been seen in order, it updates a one-hot bank enable. It also drives a flag that tells the data bus driver whether any bank currently answers.

The host interface is a single-cycle strobe, `rd_done`, synchronous to `clk`. It marks the end of a read cycle (enable low, write enable high) and comes with the four sampled address bits. There is no back-pressure: the recognizer accepts a strobe on every cycle, so the interface has no ready signal. Write cycles never raise the strobe, and all other address bits are never routed to the block, so neither can touch the recognizer.

`addr_hi` is packed as bit 0 = A8, bit 1 = A9, bit 2 = A10, bit 3 = A11.

Top module: `bank_seq_switch`

## Requirements
- R1: After reset, `bank_en` is all zeros and `bank_any` is 0.
- R2: Key steps sent without a preceding `addr_hi` = 4'hF strobe change nothing.
- R3: The key is sent after a 4'hF preamble strobe, in the following order.
  - Steps 0 to 10 use these `addr_hi` values: 5, A, 5, A, A, A, 5, 5, A, 5, A (hex).
  - Steps 11 to 13 must have `addr_hi[3:1]` = 3'b010.
  - Steps 14 and 15 must have `addr_hi[3:1]` = 3'b101.
  - If `addr_hi[0]` is 1 at step 11, bank n is enabled, where n is formed from `addr_hi[0]` of steps 12, 13, 14 and 15, most significant bit first.
  - The new selection is visible after the clock edge that samples step 15.
- R4: If `addr_hi[0]` is 0 at step 11, a completed key deselects every bank. In that case `addr_hi[0]` at steps 12 to 15 is free.
- R5: A strobe that matches neither the expected step nor 4'hF abandons the key and leaves the current selection unchanged. Further key steps then have no effect until a new preamble arrives.
- R6: A 4'hF strobe at any point restarts the key at step 0.
- R7: If the completed key names a bank number at or above parameter `NUM_BANKS`, all banks are deselected and `bank_any` is 0.
- R8: Cycles without `rd_done` never change `bank_en`, `bank_any` or the key progress, whatever `addr_hi` carries.
- R9: At most one bit of `bank_en` is set. `bank_any` is 1 exactly when one bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up) |
| rd_done | input | 1 | One-cycle pulse at the end of a read cycle |
| addr_hi | input | 4 | Sampled address lines A8..A11 (bit 0 = A8) |
| bank_en | output | 16 | One-hot bank enable, bit n enables bank n |
| bank_any | output | 1 | High while some bank is enabled (data bus enable) |

## Verification
The key is tried in several forms:
- complete with a preamble;
- complete with no preamble;
- cut off by a wrong nibble in mid-sequence;
- cut off by a second preamble.

Together these separate a recognizer that needs the preamble and resets on errors from one that merely counts matching nibbles. Complete keys name bank 5, 0, 15, 11 and 13, plus a deselect key whose free A8 bits are nonzero. This exposes errors in bit order and in the meaning of the action bit. A second instance with twelve populated banks shows how out-of-range banks are handled. Idle cycles carry changing address values, to show that the strobe alone gates sampling.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  localparam int unsigned NIB_W      = 4;
  localparam int unsigned SEQ_STEPS  = 16;
  localparam int unsigned STEP_W     = $clog2(SEQ_STEPS);
  localparam int unsigned FREE_FIRST = 11;
  localparam int unsigned MAX_BANKS  = 16;
  localparam int unsigned SEL_W      = $clog2(MAX_BANKS);
  localparam logic [NIB_W-1:0] PREAMBLE = 4'hF;

  // bit k set: step k expects 4'h5, clear: 4'hA (steps 0..10)
  localparam logic [FREE_FIRST-1:0] FIXED_PHASE = 11'b01011000101;

  typedef struct packed {
    logic [NIB_W-1:0] val;
    logic [NIB_W-1:0] care;
  } step_pat_t;

  function automatic step_pat_t step_pattern(input int unsigned idx);
    step_pat_t p;
    if (idx < FREE_FIRST) begin
      p.val  = FIXED_PHASE[idx] ? 4'h5 : 4'hA;
      p.care = 4'hF;
    end else if (idx < FREE_FIRST + 3) begin
      p.val  = 4'b0100;
      p.care = 4'b1110;
    end else begin
      p.val  = 4'b1010;
      p.care = 4'b1110;
    end
    return p;
  endfunction
endpackage

// File: rtl/bsw_pattern_rom.sv
module bsw_pattern_rom
  import bsw_pkg::*;
#(
  parameter int unsigned STEPS = SEQ_STEPS
) (
  input  logic [STEP_W-1:0] step_i,
  output logic [NIB_W-1:0]  val_o,
  output logic [NIB_W-1:0]  care_o
);
  step_pat_t rom [STEPS];

  for (genvar g = 0; g < STEPS; g++) begin : g_rom
    assign rom[g] = step_pattern(g);
  end

  assign val_o  = rom[step_i].val;
  assign care_o = rom[step_i].care;
endmodule

// File: rtl/bsw_step_ctrl.sv
module bsw_step_ctrl
  import bsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic [NIB_W-1:0]  pat_val_i,
  input  logic [NIB_W-1:0]  pat_care_i,
  output logic [STEP_W-1:0] step_o,
  output logic              commit_o,
  output logic              act_o,
  output logic [SEL_W-1:0]  num_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_STEPS - 1);
  localparam logic [STEP_W-1:0] FREE_STEP = STEP_W'(FREE_FIRST);

  logic              armed_q;
  logic [STEP_W-1:0] step_q;
  logic [SEL_W-1:0]  cap_q;   // A8 of steps 11..14, oldest in MSB
  logic              is_pre;
  logic              hit;
  logic              adv;

  assign is_pre = (nib_i == PREAMBLE);
  assign hit    = (((nib_i ^ pat_val_i) & pat_care_i) == '0);
  assign adv    = strobe_i && armed_q && !is_pre && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      step_q  <= '0;
      cap_q   <= '0;
    end else if (strobe_i) begin
      if (is_pre) begin
        armed_q <= 1'b1;
        step_q  <= '0;
      end else if (adv) begin
        if (step_q >= FREE_STEP) cap_q <= {cap_q[SEL_W-2:0], nib_i[0]};
        if (step_q == LAST_STEP) begin
          armed_q <= 1'b0;
          step_q  <= '0;
        end else begin
          step_q  <= step_q + 1'b1;
        end
      end else begin
        armed_q <= 1'b0;
        step_q  <= '0;
      end
    end
  end

  assign step_o   = step_q;
  assign commit_o = adv && (step_q == LAST_STEP);
  assign act_o    = cap_q[SEL_W-1];
  assign num_o    = {cap_q[SEL_W-2:0], nib_i[0]};

  // R6
  preamble_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && nib_i == PREAMBLE) |=> (armed_q && step_q == '0));
  // R5
  mismatch_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !is_pre && !hit) |=> !armed_q);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> ($stable(step_q) && $stable(armed_q)));
endmodule

// File: rtl/bsw_bank_reg.sv
module bsw_bank_reg
  import bsw_pkg::*;
#(
  parameter int unsigned NUM_BANKS = MAX_BANKS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit_i,
  input  logic                 act_i,
  input  logic [SEL_W-1:0]     num_i,
  output logic [MAX_BANKS-1:0] en_o,
  output logic                 any_o
);
  localparam logic [SEL_W:0] POP = (SEL_W+1)'(NUM_BANKS);

  logic in_range;
  logic any_q;

  assign in_range = ({1'b0, num_i} < POP);

  for (genvar g = 0; g < MAX_BANKS; g++) begin : g_bank
    if (g < NUM_BANKS) begin : g_pop
      localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
      logic en_q;
      always_ff @(posedge clk) begin
        if (!rst_n)        en_q <= 1'b0;
        else if (commit_i) en_q <= act_i && (num_i == IDX);
      end
      assign en_o[g] = en_q;
    end else begin : g_empty
      assign en_o[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        any_q <= 1'b0;
    else if (commit_i) any_q <= act_i && in_range;
  end
  assign any_o = any_q;

  // R9
  single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_o));
  // R9
  any_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_o == (en_o != '0));
  // R4
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !act_i) |=> (en_o == '0 && !any_o));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(en_o) && $stable(any_o)));
endmodule

// File: rtl/bank_seq_switch.sv
module bank_seq_switch
  import bsw_pkg::*;
#(
  parameter int unsigned NUM_BANKS = MAX_BANKS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_done,
  input  logic [NIB_W-1:0]     addr_hi,
  output logic [MAX_BANKS-1:0] bank_en,
  output logic                 bank_any
);
  logic [STEP_W-1:0] step;
  logic [NIB_W-1:0]  pat_val;
  logic [NIB_W-1:0]  pat_care;
  logic              commit;
  logic              act;
  logic [SEL_W-1:0]  num;

  bsw_pattern_rom #(.STEPS(SEQ_STEPS)) u_rom (
    .step_i (step),
    .val_o  (pat_val),
    .care_o (pat_care)
  );

  bsw_step_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_i   (rd_done),
    .nib_i      (addr_hi),
    .pat_val_i  (pat_val),
    .pat_care_i (pat_care),
    .step_o     (step),
    .commit_o   (commit),
    .act_o      (act),
    .num_o      (num)
  );

  bsw_bank_reg #(.NUM_BANKS(NUM_BANKS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (commit),
    .act_i    (act),
    .num_i    (num),
    .en_o     (bank_en),
    .any_o    (bank_any)
  );

  // R8
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> ($stable(bank_en) && $stable(bank_any)));
endmodule

// File: tb/bank_seq_switch_bench.sv
module bank_seq_switch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SMALL_BANKS = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_done = 1'b0;
  logic [3:0]  addr_hi = 4'h0;
  logic [15:0] en_big, en_small;
  logic        any_big, any_small;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_seq_switch u_bank_seq_switch (
    .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .addr_hi(addr_hi),
    .bank_en(en_big), .bank_any(any_big));

  bank_seq_switch #(.NUM_BANKS(SMALL_BANKS)) u_small (
    .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .addr_hi(addr_hi),
    .bank_en(en_small), .bank_any(any_small));

  // Key written as A8 A9 A10 A11 (A8 leftmost) for steps 0..10
  function automatic logic [3:0] fixed_digits(input int k);
    logic [3:0] t [11] = '{4'b1010, 4'b0101, 4'b1010, 4'b0101, 4'b0101,
                           4'b0101, 4'b1010, 4'b1010, 4'b0101, 4'b1010, 4'b0101};
    return t[k];
  endfunction

  // Converts A8..A11 digits to port packing {A11,A10,A9,A8}
  function automatic logic [3:0] to_port(input logic [3:0] d);
    return {d[0], d[1], d[2], d[3]};
  endfunction

  // A9 A10 A11 digits for the free-A8 steps
  function automatic logic [2:0] tail_digits(input int k);
    return (k <= 13) ? 3'b010 : 3'b101;
  endfunction

  function automatic logic [3:0] key_nib(input int k, input bit act, input int bank);
    logic a8;
    if (k < 11) return to_port(fixed_digits(k));
    if (k == 11) a8 = act;
    else a8 = bank[15-k];
    return to_port({a8, tail_digits(k)});
  endfunction

  function automatic bit nib_ok(input int k, input logic [3:0] n);
    if (k < 11) return n == to_port(fixed_digits(k));
    return n[3:1] == to_port({1'b0, tail_digits(k)})[3:1];
  endfunction

  // Behavioural reference model
  bit m_armed;
  int m_step;
  bit m_act;
  int m_bk;
  int m_sel = -1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_armed = 0; m_step = 0; m_sel = -1; m_bk = 0; m_act = 0;
    end else if (rd_done) begin
      if (addr_hi == 4'hF) begin
        m_armed = 1; m_step = 0; m_bk = 0;
      end else if (m_armed && nib_ok(m_step, addr_hi)) begin
        if (m_step == 11) m_act = addr_hi[0];
        if (m_step >= 12) m_bk = m_bk * 2 + int'(addr_hi[0]);
        if (m_step == 15) begin
          m_sel = m_act ? m_bk : -1;
          m_armed = 0; m_step = 0;
        end else m_step++;
      end else begin
        m_armed = 0; m_step = 0;
      end
    end
  end

  function automatic logic [15:0] exp_en(input int limit);
    if (m_sel < 0 || m_sel >= limit) return 16'h0;
    return 16'h1 << m_sel;
  endfunction

  task automatic check16(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check16(cur_req, en_big, exp_en(16));
      check16(cur_req, en_small, exp_en(SMALL_BANKS));
      check16({cur_req, "/R9"}, {15'h0, any_big}, {15'h0, exp_en(16) != 0});
      check16({cur_req, "/R9"}, {15'h0, any_small}, {15'h0, exp_en(SMALL_BANKS) != 0});
    end
  end

  task automatic pulse(input logic [3:0] n);
    @(negedge clk);
    rd_done = 1'b1; addr_hi = n;
    @(negedge clk);
    rd_done = 1'b0; addr_hi = n ^ 4'h6;
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      rd_done = 1'b0; addr_hi = 4'(i * 7 + 3);
    end
  endtask

  task automatic send_key(input bit pre, input bit act, input int bank, input int upto);
    if (pre) pulse(4'hF);
    for (int k = 0; k < upto; k++) pulse(key_nib(k, act, bank));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check16("R1", en_big, 16'h0);
    check16("R1", {15'h0, any_big}, 16'h0);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R2";
    send_key(0, 1, 5, 16);
    check16("R2", en_big, 16'h0);

    cur_req = "R3";
    send_key(1, 1, 5, 16);
    check16("R3", en_big, 16'h0020);

    cur_req = "R8";
    idle(20);
    check16("R8", en_big, 16'h0020);

    cur_req = "R3";
    send_key(1, 1, 0, 16);
    check16("R3", en_big, 16'h0001);
    send_key(1, 1, 11, 16);
    check16("R3", en_small, 16'h0800);

    cur_req = "R7";
    send_key(1, 1, 15, 16);
    check16("R7", en_big, 16'h8000);
    check16("R7", en_small, 16'h0000);
    check16("R7", {15'h0, any_small}, 16'h0);
    send_key(1, 1, 13, 16);
    check16("R7", en_small, 16'h0000);

    cur_req = "R5";
    send_key(1, 1, 3, 6);
    pulse(4'h3);
    for (int k = 6; k < 16; k++) pulse(key_nib(k, 1, 3));
    check16("R5", en_big, 16'h2000);
    send_key(1, 1, 3, 13);
    pulse(4'h0);
    pulse(key_nib(13, 1, 3)); pulse(key_nib(14, 1, 3)); pulse(key_nib(15, 1, 3));
    check16("R5", en_big, 16'h2000);

    cur_req = "R6";
    send_key(1, 1, 9, 7);
    send_key(1, 1, 9, 16);
    check16("R6", en_big, 16'h0200);
    check16("R6", en_small, 16'h0200);
    send_key(1, 1, 2, 4);
    pulse(4'hF);
    for (int k = 0; k < 16; k++) pulse(key_nib(k, 1, 6));
    check16("R6", en_big, 16'h0040);

    cur_req = "R4";
    send_key(1, 0, 10, 16);
    check16("R4", en_big, 16'h0000);
    check16("R4", {15'h0, any_big}, 16'h0);

    idle(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule